// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block replaces firmware-issued direct commands during DDR2 bring-up. After a start pulse it waits for the pad impedance calibration to report completion. It then walks every populated chip select in turn and emits the fixed JEDEC-style power-up command list as packed direct-command words. Each word goes out over a valid/ready handshake towards the memory controller's command port.

Three points in each chip's list are followed by a programmable number of idle cycles. These give the device time to settle after a precharge, after the DLL-reset mode writes and after the off-chip-driver calibration default step. The mode-register and extended-mode-register values are supplied by the integrator and sampled at start. The sequencer derives the DLL-reset variant of the mode value and the two calibration variants of the extended value on its own. A done flag signals that the last chip has been set up.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset `cmd_valid`, `busy` and `done` are all low.
- R2: Each word packs the chip select in bits 21:20, the command type in bits 19:18 (0 precharge-all, 1 auto-refresh, 2 mode/extended-mode write, 3 NOP), the bank in bits 17:16 and the payload in bits 15:0; bits 31:22 are zero, so the deep power-down flag in bit 22 is never set.
- R3: For each chip the twelve words come in this order: NOP, precharge-all, mode write bank 2, mode write bank 3, mode write bank 1, mode write bank 0, precharge-all, auto-refresh, auto-refresh, mode write bank 0, mode write bank 1, mode write bank 1; the bank 2, 3 and first bank 1 writes carry payload 0, and the NOP, precharge-all and auto-refresh words carry bank 0 and payload 0.
- R4: The first bank-0 mode write carries the sampled mode value with bit 8 (DLL reset) forced to 1; the second carries it with bit 8 forced to 0.
- R5: The last two bank-1 writes carry the sampled extended value with bit 14 forced to 1 and bits 9:7 forced to 7 (calibration default) and then to 0 (calibration exit).
- R6: No word is offered until bit 8 of `calib_status` has been seen high after start.
- R7: Chips are set up in ascending order from 0; a `chip_count` of 0 is treated as 1 and a value above 4 as 4.
- R8: With `cmd_ready` held high, exactly GAP_CYCLES idle cycles follow the acceptance of the first precharge-all, of the second bank-0 mode write and of the calibration-default write, and no other idle cycle lies between words of a run.
- R9: While `cmd_valid` is high and `cmd_ready` low, `cmd_valid` stays high and `cmd_word` stays unchanged; each accepted word advances the list by one.
- R10: `chip_count`, `mode_val` and `ext_val` are sampled at the accepted start; a start pulse while busy and later changes to these inputs have no effect on the run.
- R11: `done` goes high once the last word of the last chip is accepted, stays high with `cmd_valid` low until the next start, and is low with `busy` high in the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the power-up list |
| chip_count | input | 3 | Number of populated chip selects |
| mode_val | input | 16 | Base mode-register payload |
| ext_val | input | 16 | Base extended-mode-register payload |
| calib_status | input | STATUS_W | Status word from the pad logic; bit 8 means calibration done |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Controller accepts the offered word |
| cmd_word | output | 32 | Packed direct-command word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All chips initialized |

## Verification
The assertions assume that the downstream port eventually raises `cmd_ready` and that the calibration bit does arrive. The gap and hold properties also rely on `cmd_ready` never being sampled while `cmd_valid` is low to mean anything. The bench keeps within this by toggling `cmd_ready` from a free-running pseudo-random pattern that is high about half the time. It raises the calibration bit after a bounded hold-off. Start pulses and configuration changes are driven one time unit after a rising edge, so every sampled input is settled.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int PAY_W       = 16;
    localparam int WORD_W      = 32;
    localparam int CHIP_W      = 2;
    localparam int MAX_CHIPS   = 4;
    localparam int STEP_W      = 4;
    localparam int LAST_STEP   = 14;
    localparam int DLL_BIT     = 8;
    localparam int OCD_LO      = 7;
    localparam int MODESET_BIT = 14;
    localparam int CAL_BIT     = 8;

    typedef enum logic [1:0] {
        CT_PREA = 2'd0,
        CT_REF  = 2'd1,
        CT_MRS  = 2'd2,
        CT_NOP  = 2'd3
    } cmd_type_e;

    typedef enum logic [2:0] {
        PS_ZERO,
        PS_MODE_DLL,
        PS_MODE_RUN,
        PS_OCD_DFLT,
        PS_OCD_EXIT
    } pay_sel_e;

    typedef struct packed {
        logic      is_gap;
        cmd_type_e ctype;
        logic [1:0] bank;
        pay_sel_e  psel;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } state_e;

    // Per-chip list: gaps occupy their own slots so the walk is one counter.
    function automatic step_t step_at(input logic [STEP_W-1:0] idx);
        step_t s;
        s.is_gap = 1'b0;
        s.ctype  = CT_NOP;
        s.bank   = 2'd0;
        s.psel   = PS_ZERO;
        case (idx)
            4'd0:  s.ctype = CT_NOP;
            4'd1:  s.ctype = CT_PREA;
            4'd2:  s.is_gap = 1'b1;
            4'd3:  begin s.ctype = CT_MRS; s.bank = 2'd2; end
            4'd4:  begin s.ctype = CT_MRS; s.bank = 2'd3; end
            4'd5:  begin s.ctype = CT_MRS; s.bank = 2'd1; end
            4'd6:  begin s.ctype = CT_MRS; s.psel = PS_MODE_DLL; end
            4'd7:  s.ctype = CT_PREA;
            4'd8:  s.ctype = CT_REF;
            4'd9:  s.ctype = CT_REF;
            4'd10: begin s.ctype = CT_MRS; s.psel = PS_MODE_RUN; end
            4'd11: s.is_gap = 1'b1;
            4'd12: begin s.ctype = CT_MRS; s.bank = 2'd1; s.psel = PS_OCD_DFLT; end
            4'd13: s.is_gap = 1'b1;
            4'd14: begin s.ctype = CT_MRS; s.bank = 2'd1; s.psel = PS_OCD_EXIT; end
            default: s.is_gap = 1'b0;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [CHIP_W-1:0] chip,
                                                    input cmd_type_e ct,
                                                    input logic [1:0] bank,
                                                    input logic [PAY_W-1:0] pay);
        return {10'd0, chip, ct, bank, pay};
    endfunction

    // Index of the last chip to set up; out-of-range counts are clamped.
    function automatic logic [CHIP_W-1:0] last_chip(input logic [2:0] n);
        if (n == 3'd0)
            return '0;
        else if (int'(n) > MAX_CHIPS)
            return CHIP_W'(MAX_CHIPS - 1);
        else
            return CHIP_W'(n - 3'd1);
    endfunction

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
    import ddr_init_pkg::*;
(
    input  logic [STEP_W-1:0] step_idx,
    output step_t             cur_step,
    output logic              next_is_gap
);
    step_t nxt;

    always_comb begin
        cur_step    = step_at(step_idx);
        nxt         = step_at(step_idx + STEP_W'(1));
        next_is_gap = nxt.is_gap;
    end
endmodule

// File: rtl/ddr_init_payload.sv
module ddr_init_payload
    import ddr_init_pkg::*;
(
    input  pay_sel_e          psel,
    input  logic [PAY_W-1:0]  mode_base,
    input  logic [PAY_W-1:0]  ext_base,
    output logic [PAY_W-1:0]  payload
);
    always_comb begin
        payload = '0;
        case (psel)
            PS_MODE_DLL: begin
                payload          = mode_base;
                payload[DLL_BIT] = 1'b1;
            end
            PS_MODE_RUN: begin
                payload          = mode_base;
                payload[DLL_BIT] = 1'b0;
            end
            PS_OCD_DFLT: begin
                payload                     = ext_base;
                payload[OCD_LO+2:OCD_LO]    = 3'b111;
                payload[MODESET_BIT]        = 1'b1;
            end
            PS_OCD_EXIT: begin
                payload                     = ext_base;
                payload[OCD_LO+2:OCD_LO]    = 3'b000;
                payload[MODESET_BIT]        = 1'b1;
            end
            default: payload = '0;
        endcase
    end
endmodule

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
    parameter int GAP_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(GAP_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int GAP_CYCLES = 10,
    parameter int STATUS_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          chip_count,
    input  logic [PAY_W-1:0]    mode_val,
    input  logic [PAY_W-1:0]    ext_val,
    input  logic [STATUS_W-1:0] calib_status,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [WORD_W-1:0]   cmd_word,
    output logic                busy,
    output logic                done
);
    state_e              st_q, st_d;
    logic [STEP_W-1:0]   step_q, step_d;
    logic [CHIP_W-1:0]   chip_q, chip_d, last_q, last_d;
    logic [PAY_W-1:0]    mode_q, ext_q;
    logic                take_start;
    logic                tmr_load, tmr_expired;
    step_t               cur;
    logic                gap_next;
    logic [PAY_W-1:0]    pay;
    logic                unused_status;

    assign unused_status = ^{calib_status[STATUS_W-1:CAL_BIT+1], calib_status[CAL_BIT-1:0]};

    ddr_init_step_rom u_rom (
        .step_idx    (step_q),
        .cur_step    (cur),
        .next_is_gap (gap_next)
    );

    ddr_init_payload u_pay (
        .psel      (cur.psel),
        .mode_base (mode_q),
        .ext_base  (ext_q),
        .payload   (pay)
    );

    ddr_init_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    assign take_start = start && (st_q == ST_IDLE || st_q == ST_DONE);

    always_comb begin
        st_d     = st_q;
        step_d   = step_q;
        chip_d   = chip_q;
        last_d   = last_q;
        tmr_load = 1'b0;
        case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    st_d   = ST_CAL;
                    last_d = last_chip(chip_count);
                end
            end
            ST_CAL: begin
                if (calib_status[CAL_BIT]) begin
                    st_d   = ST_ISSUE;
                    step_d = '0;
                    chip_d = '0;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (step_q == STEP_W'(LAST_STEP)) begin
                        if (chip_q == last_q) begin
                            st_d = ST_DONE;
                        end else begin
                            chip_d = chip_q + CHIP_W'(1);
                            step_d = '0;
                        end
                    end else begin
                        step_d = step_q + STEP_W'(1);
                        if (gap_next) begin
                            st_d     = ST_GAP;
                            tmr_load = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    step_d = step_q + STEP_W'(1);
                    st_d   = ST_ISSUE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            chip_q <= '0;
            last_q <= '0;
            mode_q <= '0;
            ext_q  <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            chip_q <= chip_d;
            last_q <= last_d;
            if (take_start) begin
                mode_q <= mode_val;
                ext_q  <= ext_val;
            end
        end
    end

    assign cmd_valid = (st_q == ST_ISSUE);
    assign cmd_word  = pack_word(chip_q, cur.ctype, cur.bank, pay);
    assign busy      = (st_q == ST_CAL) || (st_q == ST_ISSUE) || (st_q == ST_GAP);
    assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int GAP_CYCLES = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        cal_bit,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_word,
    input logic        busy,
    input logic        done
);
    logic        cal_ok;
    logic        first_q;
    logic [15:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            cal_ok <= 1'b0;
        else if (cal_bit)
            cal_ok <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            first_q <= 1'b0;
        else if (start && !busy)
            first_q <= 1'b1;
        else if (cmd_valid && cmd_ready)
            first_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            idle_q <= '0;
        else if (cmd_valid && cmd_ready)
            idle_q <= '0;
        else if (!cmd_valid && idle_q != 16'hFFFF)
            idle_q <= idle_q + 16'd1;
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));

    a_r6_after_calib: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cal_ok);

    a_r8_gap_length: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) && !first_q |-> idle_q == 16'(GAP_CYCLES));

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid && !busy);

    a_r11_restart: assert property (@(posedge clk) disable iff (rst)
        done && start |=> !done && busy);

    a_r2_no_dpd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_word[31:22] == 10'd0);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cal_bit   (calib_status[8]),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
    localparam int GAP = 10;

    typedef struct packed {
        logic [2:0]  n;
        logic [15:0] m;
        logic [15:0] e;
        logic        st;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd1, 16'h0642, 16'h0044, 1'b0},
        '{3'd2, 16'h0742, 16'h03C6, 1'b1},
        '{3'd4, 16'h0A53, 16'h0004, 1'b0},
        '{3'd3, 16'h0000, 16'hFFFF, 1'b1},
        '{3'd0, 16'h1234, 16'h0040, 1'b0},
        '{3'd7, 16'h00F2, 16'h0002, 1'b1}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [2:0]  chip_count = 0;
    logic [15:0] mode_val = 0;
    logic [15:0] ext_val = 0;
    logic [15:0] calib_status = 16'h0100;
    logic        cmd_valid;
    logic        cmd_ready = 1;
    logic [31:0] cmd_word;
    logic        busy;
    logic        done;

    int nchk = 0;
    int nfail = 0;
    bit stall = 0;
    logic [7:0] lfsr = 8'hA5;

    logic [31:0] cap_w [0:63];
    int          cap_c [0:63];
    int          cap_n = 0;
    int          cyc = 0;
    bit          hold_pend = 0;
    logic [31:0] held_w;

    ddr_init_seq #(.GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .start(start), .chip_count(chip_count),
        .mode_val(mode_val), .ext_val(ext_val), .calib_status(calib_status),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expw(input int idx, input logic [15:0] m, input logic [15:0] e);
        int c = idx / 12;
        int k = idx % 12;
        logic [1:0] t = 2'd0;
        logic [1:0] b = 2'd0;
        logic [15:0] p = 16'd0;
        case (k)
            0: t = 2'd3;
            1: t = 2'd0;
            2: begin t = 2'd2; b = 2'd2; end
            3: begin t = 2'd2; b = 2'd3; end
            4: begin t = 2'd2; b = 2'd1; end
            5: begin t = 2'd2; p = m | 16'h0100; end
            6: t = 2'd0;
            7: t = 2'd1;
            8: t = 2'd1;
            9: begin t = 2'd2; p = m & ~16'h0100; end
            10: begin t = 2'd2; b = 2'd1; p = (e & ~16'h0380) | 16'h0380 | 16'h4000; end
            default: begin t = 2'd2; b = 2'd1; p = (e & ~16'h0380) | 16'h4000; end
        endcase
        return {10'd0, 2'(c), t, b, p};
    endfunction

    // ready pattern, driven just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = stall ? lfsr[0] : 1'b1;
        end
    end

    // monitor, sampled at falling edges
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (hold_pend)
                chk(cmd_valid && cmd_word == held_w, "R9", cmd_word, held_w);
            hold_pend = cmd_valid && !cmd_ready;
            held_w    = cmd_word;
            if (cmd_valid && cmd_ready && cap_n < 64) begin
                cap_w[cap_n] = cmd_word;
                cap_c[cap_n] = cyc;
                cap_n++;
            end
        end
    end

    task automatic run(input logic [2:0] n, input logic [15:0] m, input logic [15:0] e,
                       input bit st, input bit poke, input bit holdcal);
        int nch = (n == 0) ? 1 : (n > 4) ? 4 : int'(n);
        int tot = 12 * nch;
        int g = 0;
        stall = st;
        calib_status = holdcal ? 16'hFEFF : 16'h0100;
        @(posedge clk); #1;
        chip_count = n; mode_val = m; ext_val = e; cap_n = 0; start = 1;
        @(posedge clk); #1;
        start = 0; chip_count = 3'd2; mode_val = 16'hDEAD; ext_val = 16'hBEEF;  // R10
        @(negedge clk);
        chk(!done && busy, "R11", {30'd0, done, busy}, 32'h1);
        if (holdcal) begin
            repeat (40) @(negedge clk);
            chk(cap_n == 0 && !cmd_valid && busy, "R6", cap_n, 0);
            @(posedge clk); #1;
            calib_status = 16'h0100;
        end
        if (poke) begin
            while (cap_n < 5) @(posedge clk);
            #1; start = 1; chip_count = 3'd1; mode_val = 16'h0000;
            @(posedge clk); #1; start = 0;
        end
        while (!done && g < 5000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
        chk(done, "R11", {31'd0, done}, 32'h1);
        chk(cap_n == tot, "R7 R10 count", cap_n, tot);
        for (int i = 0; i < tot && i < 64; i++) begin
            int k = i % 12;
            string req = (k == 5 || k == 9) ? "R4" : (k >= 10) ? "R5" : "R3 R2 R7";
            chk(cap_w[i] == expw(i, m, e), req, cap_w[i], expw(i, m, e));
        end
        if (!st) begin
            for (int i = 1; i < tot && i < 64; i++) begin
                int k = i % 12;
                int ex = (k == 2 || k == 10 || k == 11) ? GAP + 1 : 1;
                chk(cap_c[i] - cap_c[i-1] == ex, "R8", cap_c[i] - cap_c[i-1], ex);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!cmd_valid && !busy && !done, "R1", {29'd0, cmd_valid, busy, done}, 0);

        for (int v = 0; v < 6; v++)
            run(VECS[v].n, VECS[v].m, VECS[v].e, VECS[v].st, 1'b0, 1'b0);

        // calibration hold-off
        run(3'd2, 16'h0532, 16'h0046, 1'b0, 1'b0, 1'b1);
        // start while busy must be ignored
        run(3'd3, 16'h0642, 16'h0004, 1'b0, 1'b1, 1'b0);
        // done holds until the next start
        repeat (20) @(negedge clk);
        chk(done && !cmd_valid && !busy, "R11", {29'd0, done, cmd_valid, busy}, 32'h4);
        run(3'd1, 16'h0F00, 16'h0380, 1'b1, 1'b0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        #1_500_000;
        nfail++;
        nchk++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule